// File: doc/BRIEF.md
# Dual-Bus CAN Repeater Logic

This block is the digital decision core of a transceiver pair that joins two CAN bus segments into one logical bus. It takes a local transmit request from a protocol controller, an expansion transmit request from a neighbouring repeater core, and the digitised receive level of each bus segment. From these it produces a drive request for each segment, a receive level for the local controller and a receive level for the expansion chain. Every digital signal uses low for dominant and high for recessive. Comparators, slope-controlled drivers and the line interface stay outside the block. Receive inputs arrive as clean synchronous levels.

Either segment can be taken out of service with its disable input. A disabled segment is never driven, and its receiver reads as permanently recessive. A dominant level seen on one segment is forwarded to the other segment and to both receive outputs, with no priority between the segments. A segment this block drives dominant will show that dominant back on its own receiver. To keep that echo from latching both segments dominant, reception from a segment is masked while the block drives it. The mask also holds for a parameterised release delay, counted in clock cycles, after the drive ends.

All outputs are registered. Each output reflects the inputs one clock edge earlier.

Top module: `dual_can_repeater`

## Requirements
- R1: Low means dominant and high means recessive on every port. All outputs are registered with one cycle of latency. During reset and right after it, all four outputs are recessive (high).
- R2: A dominant level received on an enabled segment, while that segment is not masked, drives the other enabled segment dominant. On the next cycle it also pulls both `loc_rx_n` and `exp_rx_n` low.
- R3: A low `loc_tx_n` drives every enabled segment dominant and pulls both `loc_rx_n` and `exp_rx_n` low on the next cycle, whatever the disables are.
- R4: A low `exp_tx_n` drives every enabled segment dominant and pulls `loc_rx_n` low on the next cycle. `exp_rx_n` stays high unless another source is dominant.
- R5: While `bus_off[b]` is high, `line_tx_n[b]` is high (bit 0 is segment A, bit 1 is segment B).
- R6: While `bus_off[b]` is high, `line_rx_n[b]` has no effect on any output.
- R7: Reception from a segment is masked while the block drives that segment. It stays masked for exactly `REL_CYC` further cycles after the drive ends. The delay restarts at every release. A dominant level arriving at the moment of release reaches the outputs `REL_CYC`+2 edges later.
- R8: A dominant level received on a segment never re-drives that same segment. After an external dominant on one segment ends, all outputs return to recessive within `REL_CYC`+3 cycles, so no permanent interlock forms.
- R9: Segments A and B are handled symmetrically in both forwarding and masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_tx_n | input | 1 | Local transmit request, low = dominant |
| exp_tx_n | input | 1 | Expansion transmit request, low = dominant |
| line_rx_n | input | 2 | Received level per segment, low = dominant |
| bus_off | input | 2 | Per-segment disable, high = disabled |
| line_tx_n | output | 2 | Drive request per segment, low = drive dominant |
| loc_rx_n | output | 1 | Receive level for the local controller |
| exp_rx_n | output | 1 | Receive level for the expansion chain |

## Verification
The assertions check on every cycle the transmit-path rules, the asymmetry of the expansion path, the forcing of disabled drivers to recessive, and the isolation of a disabled receiver. They also check that a segment is never re-driven by its own reception, and that a dominant from an unmasked segment is forwarded; a checker counter decides whether the mask has expired. Only the bench scenarios can show the exact length of the release window and its restart after a second short drive. They also cover the full recovery to recessive after an external dominant ends, and the exhaustive table of disable and transmit combinations, all against a model of the wired bus in which the block's own drive reappears on its receivers.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
   localparam logic LVL_DOM = 1'b0;
   localparam logic LVL_REC = 1'b1;
   localparam int   NSEG    = 2;

   function automatic logic is_dom(input logic lvl_n);
      return lvl_n == LVL_DOM;
   endfunction

   function automatic logic to_lvl(input logic dom);
      return dom ? LVL_DOM : LVL_REC;
   endfunction
endpackage

// File: rtl/rptr_rx_gate.sv
// Per-segment receive qualification: disable gating plus echo mask with
// a release hold-off that restarts whenever the drive on this segment ends.
module rptr_rx_gate #(
   parameter int REL_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   input  logic seg_off,
   input  logic drv_q,
   input  logic drv_d,
   output logic rx_dom
);
   import rptr_pkg::*;
   localparam int CNT_W = (REL_CYC < 2) ? 1 : $clog2(REL_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REL_CYC);

   logic [CNT_W-1:0] hold_cnt;
   logic             masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
      end else if (drv_q) begin
         hold_cnt <= drv_d ? '0 : CNT_LOAD;
      end else if (hold_cnt != '0) begin
         hold_cnt <= hold_cnt - 1'b1;
      end
   end

   assign masked = drv_q || (hold_cnt != '0);
   assign rx_dom = is_dom(line_n) && !seg_off && !masked;
endmodule

// File: rtl/rptr_fwd.sv
// Forwarding matrix: which sources reach which segment and which receive output.
module rptr_fwd (
   input  logic       loc_dom,
   input  logic       exp_dom,
   input  logic [1:0] rx_dom,
   input  logic [1:0] seg_off,
   output logic [1:0] drv_d,
   output logic       loc_rx_dom,
   output logic       exp_rx_dom
);
   logic tx_any;
   assign tx_any = loc_dom || exp_dom;

   for (genvar b = 0; b < 2; b++) begin : g_seg
      // a segment is fed by the transmit inputs and the opposite segment only
      assign drv_d[b] = (tx_any || rx_dom[1-b]) && !seg_off[b];
   end

   assign loc_rx_dom = tx_any  || (|rx_dom);
   assign exp_rx_dom = loc_dom || (|rx_dom);
endmodule

// File: rtl/dual_can_repeater.sv
module dual_can_repeater #(
   parameter int REL_CYC = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       loc_tx_n,
   input  logic       exp_tx_n,
   input  logic [1:0] line_rx_n,
   input  logic [1:0] bus_off,
   output logic [1:0] line_tx_n,
   output logic       loc_rx_n,
   output logic       exp_rx_n
);
   import rptr_pkg::*;

   if (REL_CYC < 1) begin : g_bad_rel
      $error("REL_CYC must be at least 1");
   end

   logic [1:0] drv_q, drv_d, rx_dom;
   logic       loc_rx_dom, exp_rx_dom;
   logic       loc_rx_q, exp_rx_q;

   for (genvar b = 0; b < NSEG; b++) begin : g_rx
      rptr_rx_gate #(.REL_CYC(REL_CYC)) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_n  (line_rx_n[b]),
         .seg_off (bus_off[b]),
         .drv_q   (drv_q[b]),
         .drv_d   (drv_d[b]),
         .rx_dom  (rx_dom[b])
      );
   end

   rptr_fwd u_fwd (
      .loc_dom    (is_dom(loc_tx_n)),
      .exp_dom    (is_dom(exp_tx_n)),
      .rx_dom     (rx_dom),
      .seg_off    (bus_off),
      .drv_d      (drv_d),
      .loc_rx_dom (loc_rx_dom),
      .exp_rx_dom (exp_rx_dom)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q    <= '0;
         loc_rx_q <= 1'b0;
         exp_rx_q <= 1'b0;
      end else begin
         drv_q    <= drv_d;
         loc_rx_q <= loc_rx_dom;
         exp_rx_q <= exp_rx_dom;
      end
   end

   for (genvar b = 0; b < NSEG; b++) begin : g_out
      assign line_tx_n[b] = to_lvl(drv_q[b]);
   end
   assign loc_rx_n = to_lvl(loc_rx_q);
   assign exp_rx_n = to_lvl(exp_rx_q);
endmodule

// File: rtl/dual_can_repeater_chk.sv
module dual_can_repeater_chk #(
   parameter int REL_CYC = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       loc_tx_n,
   input logic       exp_tx_n,
   input logic [1:0] line_rx_n,
   input logic [1:0] bus_off,
   input logic [1:0] line_tx_n,
   input logic       loc_rx_n,
   input logic       exp_rx_n
);
   // cycles each segment has been left undriven, saturating
   int unsigned quiet_a, quiet_b;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_a <= 0;
         quiet_b <= 0;
      end else begin
         quiet_a <= !line_tx_n[0] ? 0 : ((quiet_a <= REL_CYC) ? quiet_a + 1 : quiet_a);
         quiet_b <= !line_tx_n[1] ? 0 : ((quiet_b <= REL_CYC) ? quiet_b + 1 : quiet_b);
      end
   end

   AST_LOC_TX_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_tx_n |=> !loc_rx_n && !exp_rx_n); // R3
   AST_LOC_TX_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!loc_tx_n && !bus_off[1]) |=> !line_tx_n[1]); // R3
   AST_EXP_TX_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      !exp_tx_n |=> !loc_rx_n); // R4
   AST_OFF_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off[0] |=> line_tx_n[0]); // R5
   AST_OFF_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off[1] |=> line_tx_n[1]); // R5
   AST_OFF_RX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off[0] && loc_tx_n && exp_tx_n && (bus_off[1] || line_rx_n[1]))
      |=> loc_rx_n && exp_rx_n && line_tx_n[1]); // R6
   AST_NO_SELF_REDRIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_tx_n && exp_tx_n && (line_rx_n[1] || bus_off[1])) |=> line_tx_n[0]); // R8
   AST_NO_SELF_REDRIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_tx_n && exp_tx_n && (line_rx_n[0] || bus_off[0])) |=> line_tx_n[1]); // R9
   AST_FWD_A_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_rx_n[0] && !bus_off[0] && !bus_off[1] && line_tx_n[0] && quiet_a > REL_CYC)
      |=> !line_tx_n[1] && !loc_rx_n && !exp_rx_n); // R2
   AST_FWD_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_rx_n[1] && !bus_off[0] && !bus_off[1] && line_tx_n[1] && quiet_b > REL_CYC)
      |=> !line_tx_n[0] && !loc_rx_n && !exp_rx_n); // R9
endmodule

bind dual_can_repeater dual_can_repeater_chk #(.REL_CYC(REL_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .loc_tx_n(loc_tx_n), .exp_tx_n(exp_tx_n),
   .line_rx_n(line_rx_n), .bus_off(bus_off), .line_tx_n(line_tx_n),
   .loc_rx_n(loc_rx_n), .exp_rx_n(exp_rx_n)
);

// File: tb/dual_can_repeater_tb.sv
`timescale 1ns/1ps
module dual_can_repeater_tb;
   localparam int REL = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       loc_tx_n = 1'b1, exp_tx_n = 1'b1;
   logic [1:0] ext_n = 2'b11;
   logic [1:0] bus_off = 2'b00;
   logic [1:0] line_rx_n, line_tx_n;
   logic       loc_rx_n, exp_rx_n;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   // wired bus: a segment is dominant if the far side or this block drives it
   assign line_rx_n = ext_n & line_tx_n;

   dual_can_repeater #(.REL_CYC(REL)) u_dut (
      .clk(clk), .rst_n(rst_n), .loc_tx_n(loc_tx_n), .exp_tx_n(exp_tx_n),
      .line_rx_n(line_rx_n), .bus_off(bus_off), .line_tx_n(line_tx_n),
      .loc_rx_n(loc_rx_n), .exp_rx_n(exp_rx_n)
   );

   task automatic chk(input string tag, input logic got, input logic want);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s got=%b exp=%b t=%0t", tag, got, want, $time);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle(input int n);
      loc_tx_n = 1'b1; exp_tx_n = 1'b1; ext_n = 2'b11; bus_off = 2'b00;
      step(n);
   endtask

   // {line_tx_n[1], line_tx_n[0], loc_rx_n, exp_rx_n} one edge after the
   // inputs are applied from an idle, unmasked state
   function automatic logic [3:0] model(input logic [1:0] off, input logic l,
                                        input logic e, input logic [1:0] ext_dom);
      logic [1:0] rxd;
      logic d0, d1;
      rxd = ext_dom & ~off;
      d0  = (l | e | rxd[1]) & ~off[0];
      d1  = (l | e | rxd[0]) & ~off[1];
      return {~d1, ~d0, ~(l | e | (|rxd)), ~(l | (|rxd))};
   endfunction

   task automatic cmp4(input string tag, input logic [3:0] want);
      chk({tag, " drive B"}, line_tx_n[1], want[3]);
      chk({tag, " drive A"}, line_tx_n[0], want[2]);
      chk({tag, " loc_rx"},  loc_rx_n,     want[1]);
      chk({tag, " exp_rx"},  exp_rx_n,     want[0]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h0C4A_2700));
      step(3);
      cmp4("R1 in reset", 4'b1111);
      rst_n = 1'b1;
      step(1);
      cmp4("R1 after reset", 4'b1111);

      // exhaustive disables x transmit inputs, external lines recessive
      for (int i = 0; i < 16; i++) begin
         idle(REL + 3);
         bus_off = i[3:2]; loc_tx_n = ~i[1]; exp_tx_n = ~i[0];
         step(1);
         cmp4("R3 R4 R5 table", model(i[3:2], i[1], i[0], 2'b00));
      end

      // random disables, transmits and external dominants
      for (int i = 0; i < 40; i++) begin
         logic [4:0] r;
         r = 5'($urandom);
         idle(REL + 3);
         bus_off = r[1:0]; loc_tx_n = ~r[2]; exp_tx_n = ~r[3];
         ext_n = ~({r[4], ~r[4]} & 2'($urandom));
         step(1);
         cmp4("R2 R6 R9 random", model(r[1:0], r[2], r[3], ~ext_n));
      end

      // sustained external dominant on each segment, then release
      for (int b = 0; b < 2; b++) begin
         idle(REL + 3);
         ext_n[b] = 1'b0;
         step(1);
         chk("R8 source not re-driven", line_tx_n[b], 1'b1);
         chk("R2 R9 forwarded",         line_tx_n[1-b], 1'b0);
         step(4);
         chk("R8 source still not re-driven", line_tx_n[b], 1'b1);
         chk("R2 forward held",               loc_rx_n, 1'b0);
         ext_n[b] = 1'b1;
         step(REL + 3);
         cmp4("R8 no interlock", 4'b1111);
      end

      // release delay with restart: drive, short gap, drive again, then a
      // dominant on segment B arrives exactly at the final release
      idle(REL + 3);
      loc_tx_n = 1'b0; step(3);
      loc_tx_n = 1'b1; step(2);
      loc_tx_n = 1'b0; step(1);
      loc_tx_n = 1'b1; ext_n[1] = 1'b0;
      step(REL + 1);
      chk("R7 still masked drive A", line_tx_n[0], 1'b1);
      chk("R7 still masked loc_rx",  loc_rx_n,     1'b1);
      step(1);
      chk("R7 mask released drive A", line_tx_n[0], 1'b0);
      chk("R7 mask released exp_rx",  exp_rx_n,     1'b0);
      idle(REL + 3);
      cmp4("R8 final idle", 4'b1111);

      finish_run();
   end
endmodule